// File: doc/BRIEF.md
# Posted-Write Register Bridge

This bridge sits between a fast bus clock domain and a slower functional clock domain of a timer peripheral. Software issues single-word register reads and writes on a valid/ready request port. A set of synchronised registers is carried into the functional domain, each over its own toggle handshake with two-flop synchronisers in both directions. The functional logic sees a one-cycle write strobe per register together with the stable written word. A second set of registers lives entirely in the bus domain and takes effect at once.

Software picks the write completion style with a mode bit. With the mode off, a write to a synchronised register stalls the bus until the functional domain has confirmed it. With the mode on, the write is acknowledged at once and a per-register pending bit, readable as one status word, tracks delivery. A posted write to a register that is still pending is discarded and sets a sticky error flag. A soft reset can be requested through the interface-control register. It is forwarded to the functional domain and reported through a done bit. The functional timer itself is outside this block.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset every pending bit is clear, posted mode is off, the sticky error is clear, the status word at index 16+NSYNC-11 (index 15 with defaults, `SYSSTAT`) reads 1, and `idle_mode` is 0.
- R2: With posted mode off, a write to a synchronised register (indices 0 to NSYNC-1) holds `req_ready` low until the functional domain has taken the word; this includes the case where that register was still pending from an earlier posted write, and the functional side then sees every accepted word in order.
- R3: With posted mode on, a write to a synchronised register that is not pending is accepted in the cycle it is presented, and the word later appears on that register's functional strobe.
- R4: The pending word at index NSYNC+4 holds bit i set while a write to synchronised register i is in flight; a bit sets only from an accepted write and clears once the functional domain confirms it.
- R5: With posted mode on, a write to a synchronised register whose pending bit is set is accepted, never reaches the functional domain, and sets a sticky error that reads as bit 1 of the status word and drives `posted_err`.
- R6: A read of a synchronised register returns the last delivered word while its write is pending and the new word once the pending bit has cleared.
- R7: The wakeup register (index NSYNC+0, driving `wake_en`) and the two capture registers (NSYNC+1, NSYNC+2) are written in the presenting cycle in either mode, have no pending bit and read back what was written.
- R8: Bit 2 of the interface-control register (index NSYNC+3) selects posted mode and reads back.
- R9: A write to interface control with bit 1 set (for example 0x06) waits until no write is pending, then starts a soft reset: posted mode, the error, the bus-domain registers and the idle field clear, bit 0 of the status word reads 0 until the functional domain has pulsed `fn_soft_rst` exactly once, then reads 1, every synchronised register reads 0 and writes stall again until delivery.
- R10: The configuration register at index NSYNC+6 keeps only its idle-mode field in bits [4:3] (value 2 is smart idle), drives it on `idle_mode`, and reads all other bits as 0.
- R11: Writes to the pending word and to the status word have no effect.
- R12: Posted writes to different synchronised registers may be pending at once without blocking each other or raising the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Synchronous active-low reset, bus domain |
| req_valid | input | 1 | Request present; held with its fields until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register index |
| req_wdata | input | DW | Write word |
| req_ready | output | 1 | Request accepted at this edge when high with `req_valid` |
| rsp_rdata | output | DW | Read word for the presented index, valid with `req_ready` |
| posted_err | output | 1 | Sticky dropped-write error |
| wake_en | output | DW | Wakeup-enable register contents |
| idle_mode | output | 2 | Idle-mode field of the configuration register |
| clk_fn | input | 1 | Functional clock |
| rst_fn_n | input | 1 | Synchronous active-low reset, functional domain |
| fn_wr_stb | output | NSYNC | One-cycle write strobe per synchronised register |
| fn_wr_data | output | NSYNC*DW | Written word per register, stable while its strobe is high |
| fn_soft_rst | output | 1 | One-cycle soft-reset pulse in the functional domain |

## Verification
The bench builds the bridge with its defaults: a 32-bit word, ten synchronised registers and a five-bit index, with a functional clock of 26 ns against the 10 ns bus clock. That ratio makes every crossing take several bus cycles, so a read issued in the cycle after a posted write reliably lands while the bit is still pending, which brings the dropped-write error, the stale readback and two simultaneously pending registers within reach. Mixing posted and stalled writes to one register and a soft reset requested while a write is still in flight exercises the ordering between modes.

// File: rtl/posted_bridge_pkg.sv
`timescale 1ns/1ps
// Shared constants of the posted-write register bridge.
// Direct-register indices are offsets above the synchronised block.
package posted_bridge_pkg;
    localparam int unsigned NSYNC_DEF      = 10;
    localparam int unsigned NDIRECT        = 7;
    localparam int unsigned OFS_WAKE       = 0;
    localparam int unsigned OFS_CAP1       = 1;
    localparam int unsigned OFS_CAP2       = 2;
    localparam int unsigned OFS_IFCTRL     = 3;
    localparam int unsigned OFS_PEND       = 4;
    localparam int unsigned OFS_SYSSTAT    = 5;
    localparam int unsigned OFS_CFG        = 6;
    localparam int unsigned IFC_SRST_BIT   = 1;
    localparam int unsigned IFC_POSTED_BIT = 2;
    localparam int unsigned IDLE_LSB       = 3;
    typedef logic [1:0] idle_mode_t;
endpackage

// File: rtl/pwb_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser for single-bit level or toggle signals.
// Assumes the input changes at most once per several destination cycles.
module pwb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    // Shift the asynchronous input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/pwb_chan.sv
`timescale 1ns/1ps
// One toggle-handshake channel carrying a word from the bus domain to the
// functional domain. A launch flips the request toggle and captures the
// word; the word stays stable until the returning acknowledge toggle
// matches, which the caller must wait for before launching again.
module pwb_chan #(
    parameter int unsigned DW = 32
) (
    input  logic          clk_bus,
    input  logic          rst_bus_n,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    input  logic          clear,
    output logic          pending,
    output logic [DW-1:0] held,
    input  logic          clk_fn,
    input  logic          rst_fn_n,
    output logic          fn_stb
);
    logic          req_t_q;
    logic          ack_s;
    logic [DW-1:0] hold_q;
    logic          req_s;
    logic          req_seen_q;

    // Flip the request toggle for every launched word.
    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n)  req_t_q <= 1'b0;
        else if (launch) req_t_q <= ~req_t_q;
    end

    // Capture the launched word; a soft reset clears it.
    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n)  hold_q <= '0;
        else if (clear)  hold_q <= '0;
        else if (launch) hold_q <= wdata;
    end

    pwb_sync2 u_ack_sync (.clk(clk_bus), .rst_n(rst_bus_n), .d(req_seen_q), .q(ack_s));
    pwb_sync2 u_req_sync (.clk(clk_fn),  .rst_n(rst_fn_n),  .d(req_t_q),    .q(req_s));

    // Remember the last request toggle seen; this doubles as the acknowledge.
    always_ff @(posedge clk_fn) begin
        if (!rst_fn_n) req_seen_q <= 1'b0;
        else           req_seen_q <= req_s;
    end

    assign pending = req_t_q ^ ack_s;
    assign held    = hold_q;
    assign fn_stb  = req_s ^ req_seen_q;
endmodule

// File: rtl/posted_reg_bridge.sv
`timescale 1ns/1ps
// Register bridge from a bus clock domain to a functional clock domain.
// Synchronised registers cross through one handshake channel each; direct
// registers live in the bus domain. Writes either stall until delivery or,
// in posted mode, complete at once with a per-register pending bit.
// Assumes the requester holds every request field stable until accepted.
module posted_reg_bridge
    import posted_bridge_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned NSYNC = NSYNC_DEF,
    parameter int unsigned AW    = $clog2(NSYNC + NDIRECT)
) (
    input  logic               clk_bus,
    input  logic               rst_bus_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_ready,
    output logic [DW-1:0]      rsp_rdata,
    output logic               posted_err,
    output logic [DW-1:0]      wake_en,
    output logic [1:0]         idle_mode,
    input  logic               clk_fn,
    input  logic               rst_fn_n,
    output logic [NSYNC-1:0]   fn_wr_stb,
    output logic [NSYNC*DW-1:0] fn_wr_data,
    output logic               fn_soft_rst
);
    localparam int unsigned IDX_WAKE    = NSYNC + OFS_WAKE;
    localparam int unsigned IDX_CAP1    = NSYNC + OFS_CAP1;
    localparam int unsigned IDX_CAP2    = NSYNC + OFS_CAP2;
    localparam int unsigned IDX_IFCTRL  = NSYNC + OFS_IFCTRL;
    localparam int unsigned IDX_PEND    = NSYNC + OFS_PEND;
    localparam int unsigned IDX_SYSSTAT = NSYNC + OFS_SYSSTAT;
    localparam int unsigned IDX_CFG     = NSYNC + OFS_CFG;

    logic [NSYNC-1:0] hit_vec, pend_vec, launch_vec, np_sel_q;
    logic [DW-1:0]    held_vals [NSYNC];
    logic [DW-1:0]    rd_vals   [NSYNC];
    logic             posted_q, err_q, rst_busy_q, np_busy_q;
    logic             drop, srst_launch, srst_clear, accept, is_wr;
    logic             soft_pend, soft_held, soft_stb;
    logic [DW-1:0]    wake_q, cap1_q, cap2_q;
    idle_mode_t       idle_q;

    assign is_wr  = req_valid && req_write;
    assign accept = req_valid && req_ready;

    // Decode the index into a one-hot hit over the synchronised block.
    always_comb begin
        for (int i = 0; i < int'(NSYNC); i++) hit_vec[i] = (int'(req_addr) == i);
    end

    // Decide acceptance, launches, drops and soft-reset start.
    always_comb begin
        req_ready   = 1'b0;
        launch_vec  = '0;
        drop        = 1'b0;
        srst_launch = 1'b0;
        if (req_valid) begin
            if (rst_busy_q) begin
                req_ready = !req_write && (int'(req_addr) == IDX_SYSSTAT);
            end else if (np_busy_q) begin
                req_ready = ((np_sel_q & pend_vec) == '0);
            end else if (req_write && (hit_vec != '0)) begin
                if ((hit_vec & pend_vec) != '0) begin
                    req_ready = posted_q;
                    drop      = posted_q;
                end else begin
                    launch_vec = hit_vec;
                    req_ready  = posted_q;
                end
            end else if (req_write && (int'(req_addr) == IDX_IFCTRL)
                         && req_wdata[IFC_SRST_BIT]) begin
                srst_launch = (pend_vec == '0);
                req_ready   = (pend_vec == '0);
            end else begin
                req_ready = 1'b1;
            end
        end
    end

    assign srst_clear = rst_busy_q && !soft_pend;

    // Track the one write that is stalling the bus in non-posted mode.
    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n) begin
            np_busy_q <= 1'b0;
            np_sel_q  <= '0;
        end else if ((launch_vec != '0) && !posted_q) begin
            np_busy_q <= 1'b1;
            np_sel_q  <= launch_vec;
        end else if (np_busy_q && accept) begin
            np_busy_q <= 1'b0;
        end
    end

    // Posted-mode bit, sticky error and soft-reset busy flag.
    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n) begin
            posted_q   <= 1'b0;
            err_q      <= 1'b0;
            rst_busy_q <= 1'b0;
        end else if (srst_launch) begin
            posted_q   <= 1'b0;
            err_q      <= 1'b0;
            rst_busy_q <= 1'b1;
        end else begin
            if (accept && is_wr && (int'(req_addr) == IDX_IFCTRL))
                posted_q <= req_wdata[IFC_POSTED_BIT];
            if (drop)       err_q      <= 1'b1;
            if (srst_clear) rst_busy_q <= 1'b0;
        end
    end

    // Bus-domain registers written directly without a crossing.
    always_ff @(posedge clk_bus) begin
        if (!rst_bus_n || srst_launch) begin
            wake_q <= '0;
            cap1_q <= '0;
            cap2_q <= '0;
            idle_q <= '0;
        end else if (accept && is_wr) begin
            if (int'(req_addr) == IDX_WAKE) wake_q <= req_wdata;
            if (int'(req_addr) == IDX_CAP1) cap1_q <= req_wdata;
            if (int'(req_addr) == IDX_CAP2) cap2_q <= req_wdata;
            if (int'(req_addr) == IDX_CFG)  idle_q <= req_wdata[IDLE_LSB +: 2];
        end
    end

    // One channel and one delivered-value register per synchronised register.
    for (genvar g = 0; g < int'(NSYNC); g++) begin : g_chan
        logic [DW-1:0] prev_q;

        pwb_chan #(.DW(DW)) u_chan (
            .clk_bus  (clk_bus),
            .rst_bus_n(rst_bus_n),
            .launch   (launch_vec[g]),
            .wdata    (req_wdata),
            .clear    (srst_clear),
            .pending  (pend_vec[g]),
            .held     (held_vals[g]),
            .clk_fn   (clk_fn),
            .rst_fn_n (rst_fn_n),
            .fn_stb   (fn_wr_stb[g])
        );

        // Keep the last delivered word for reads during a pending write.
        always_ff @(posedge clk_bus) begin
            if (!rst_bus_n || srst_clear) prev_q <= '0;
            else if (launch_vec[g])       prev_q <= held_vals[g];
        end

        assign rd_vals[g]               = pend_vec[g] ? prev_q : held_vals[g];
        assign fn_wr_data[g*DW +: DW]   = held_vals[g];
    end

    pwb_chan #(.DW(1)) u_soft_chan (
        .clk_bus  (clk_bus),
        .rst_bus_n(rst_bus_n),
        .launch   (srst_launch),
        .wdata    (1'b1),
        .clear    (1'b0),
        .pending  (soft_pend),
        .held     (soft_held),
        .clk_fn   (clk_fn),
        .rst_fn_n (rst_fn_n),
        .fn_stb   (soft_stb)
    );

    assign fn_soft_rst = soft_stb && soft_held;

    // Read multiplexer over both register sets.
    always_comb begin
        rsp_rdata = '0;
        for (int i = 0; i < int'(NSYNC); i++)
            if (hit_vec[i]) rsp_rdata = rd_vals[i];
        if (int'(req_addr) == IDX_WAKE)    rsp_rdata = wake_q;
        if (int'(req_addr) == IDX_CAP1)    rsp_rdata = cap1_q;
        if (int'(req_addr) == IDX_CAP2)    rsp_rdata = cap2_q;
        if (int'(req_addr) == IDX_IFCTRL)  rsp_rdata[IFC_POSTED_BIT] = posted_q;
        if (int'(req_addr) == IDX_PEND)    rsp_rdata[NSYNC-1:0] = pend_vec;
        if (int'(req_addr) == IDX_SYSSTAT) rsp_rdata[1:0] = {err_q, !rst_busy_q};
        if (int'(req_addr) == IDX_CFG)     rsp_rdata[IDLE_LSB +: 2] = idle_q;
    end

    assign posted_err = err_q;
    assign wake_en    = wake_q;
    assign idle_mode  = idle_q;
endmodule

// File: rtl/posted_bridge_chk.sv
`timescale 1ns/1ps
// Protocol checker for the posted-write bridge, bound into the top module.
// Observes decode, channel status and control state in the bus domain.
module posted_bridge_chk #(
    parameter int unsigned NSYNC = 10
) (
    input logic             clk_bus,
    input logic             rst_bus_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_ready,
    input logic [NSYNC-1:0] hit_vec,
    input logic [NSYNC-1:0] pend_vec,
    input logic [NSYNC-1:0] launch_vec,
    input logic             posted_q,
    input logic             err_q,
    input logic             rst_busy_q,
    input logic             np_busy_q,
    input logic             srst_launch
);
    AST_NP_NO_EARLY_ACK: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (req_valid && req_ready && req_write && (hit_vec != '0) && !posted_q)
        |-> ((hit_vec & pend_vec) == '0)); // R2

    AST_POSTED_IMMEDIATE: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (req_valid && req_write && (hit_vec != '0) && posted_q && !rst_busy_q && !np_busy_q)
        |-> req_ready); // R3

    AST_PEND_FROM_LAUNCH: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (launch_vec == '0) |=> ((pend_vec & ~$past(pend_vec)) == '0)); // R4

    AST_DROP_SETS_ERR: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (req_valid && req_write && posted_q && ((hit_vec & pend_vec) != '0)
         && !rst_busy_q && !np_busy_q) |=> err_q); // R5

    AST_ERR_STICKY: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (err_q && !srst_launch) |=> err_q); // R5

    AST_SRST_CLEARS_MODE: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        srst_launch |=> (!posted_q && !err_q && rst_busy_q)); // R9

    AST_ONE_LAUNCH: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $onehot0(launch_vec)); // R12
endmodule

bind posted_reg_bridge posted_bridge_chk #(.NSYNC(NSYNC)) u_chk (
    .clk_bus    (clk_bus),
    .rst_bus_n  (rst_bus_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .hit_vec    (hit_vec),
    .pend_vec   (pend_vec),
    .launch_vec (launch_vec),
    .posted_q   (posted_q),
    .err_q      (err_q),
    .rst_busy_q (rst_busy_q),
    .np_busy_q  (np_busy_q),
    .srst_launch(srst_launch)
);

// File: tb/posted_reg_bridge_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module posted_reg_bridge_bench;
    localparam int DW = 32;
    localparam int NS = 10;
    localparam int AW = 5;
    localparam int I_WAKE = 10, I_CAP1 = 11, I_IFC = 13, I_PEND = 14, I_STAT = 15, I_CFG = 16;

    logic clk_bus = 1'b0, clk_fn = 1'b0;
    logic rst_bus_n = 1'b0, rst_fn_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, posted_err, fn_soft_rst;
    logic [DW-1:0] rsp_rdata, wake_en;
    logic [1:0] idle_mode;
    logic [NS-1:0] fn_wr_stb;
    logic [NS*DW-1:0] fn_wr_data;

    int n_chk = 0, n_fail = 0;
    int fn_cnt [NS];
    logic [DW-1:0] fn_last [NS];
    int srst_cnt;

    always #5  clk_bus = ~clk_bus;
    always #13 clk_fn  = ~clk_fn;

    posted_reg_bridge u_posted_reg_bridge (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .posted_err(posted_err), .wake_en(wake_en), .idle_mode(idle_mode),
        .clk_fn(clk_fn), .rst_fn_n(rst_fn_n),
        .fn_wr_stb(fn_wr_stb), .fn_wr_data(fn_wr_data), .fn_soft_rst(fn_soft_rst)
    );

    // Functional-side observer of strobes and soft-reset pulses.
    always @(posedge clk_fn) begin
        if (!rst_fn_n) begin
            for (int i = 0; i < NS; i++) begin fn_cnt[i] = 0; fn_last[i] = '0; end
            srst_cnt = 0;
        end else begin
            for (int i = 0; i < NS; i++)
                if (fn_wr_stb[i]) begin
                    fn_cnt[i]  = fn_cnt[i] + 1;
                    fn_last[i] = fn_wr_data[i*DW +: DW];
                end
            if (fn_soft_rst) srst_cnt = srst_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d, output int waits);
        waits = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        #1;
        while (!req_ready && waits < 2000) begin @(negedge clk_bus); #1; waits++; end
        @(negedge clk_bus);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        int waits = 0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        #1;
        while (!req_ready && waits < 2000) begin @(negedge clk_bus); #1; waits++; end
        d = rsp_rdata;
        @(negedge clk_bus);
        req_valid = 1'b0;
    endtask

    task automatic wait_clear(input logic [31:0] mask);
        logic [31:0] v;
        for (int k = 0; k < 200; k++) begin
            bus_rd(I_PEND, v);
            if ((v & mask) == 0) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(I_PEND, v); chk("R1 pending word", v, 0);
        bus_rd(I_IFC, v);  chk("R1 posted off", v, 0);
        bus_rd(I_STAT, v); chk("R1 status", v, 1);
        chk("R1 posted_err", {31'b0, posted_err}, 0);
        chk("R1 idle_mode", {30'b0, idle_mode}, 0);
    endtask

    task automatic t_nonposted();
        int w; logic [31:0] v;
        bus_wr(0, 32'hA5A5_0001, w);
        chk("R2 write stalled", {31'b0, w > 0}, 1);
        chk("R2 delivered count", fn_cnt[0], 1);
        chk("R2 delivered word", fn_last[0], 32'hA5A5_0001);
        bus_rd(0, v);      chk("R2 readback", v, 32'hA5A5_0001);
        bus_rd(I_PEND, v); chk("R2 none pending", v, 0);
    endtask

    task automatic t_direct();
        int w; logic [31:0] v;
        bus_wr(I_WAKE, 32'h0000_F0F0, w);
        chk("R7 wake no stall", w, 0);
        chk("R7 wake_en", wake_en, 32'h0000_F0F0);
        bus_wr(I_CAP1, 32'h1111_2222, w);
        bus_rd(I_CAP1, v); chk("R7 capture readback", v, 32'h1111_2222);
        bus_rd(I_PEND, v); chk("R7 no pending bit", v, 0);
    endtask

    task automatic t_ignored();
        int w; logic [31:0] v;
        bus_wr(I_PEND, 32'hFFFF_FFFF, w);
        bus_wr(I_STAT, 32'h0, w);
        bus_rd(I_PEND, v); chk("R11 pending unchanged", v, 0);
        bus_rd(I_STAT, v); chk("R11 status unchanged", v, 1);
    endtask

    task automatic t_cfg();
        int w; logic [31:0] v;
        bus_wr(I_CFG, 32'hFFFF_FFFF, w);
        bus_rd(I_CFG, v); chk("R10 only idle field", v, 32'h18);
        chk("R10 idle_mode 3", {30'b0, idle_mode}, 3);
        bus_wr(I_CFG, 32'h10, w);
        chk("R10 smart idle", {30'b0, idle_mode}, 2);
    endtask

    task automatic t_posted();
        int w; logic [31:0] v;
        bus_wr(I_IFC, 32'h4, w);
        bus_rd(I_IFC, v);  chk("R8 posted readback", v, 32'h4);
        bus_wr(2, 32'h1234, w);
        chk("R3 immediate accept", w, 0);
        bus_rd(I_PEND, v); chk("R4 bit 2 pending", v, 32'h4);
        bus_rd(2, v);      chk("R6 old value while pending", v, 0);
        wait_clear(32'h4);
        bus_rd(2, v);      chk("R6 new value after clear", v, 32'h1234);
        chk("R3 delivered word", fn_last[2], 32'h1234);
    endtask

    task automatic t_drop();
        int w; logic [31:0] v;
        bus_wr(4, 32'h11, w);
        bus_wr(4, 32'h22, w);
        chk("R5 dropped write accepted", w, 0);
        chk("R5 posted_err set", {31'b0, posted_err}, 1);
        wait_clear(32'h10);
        bus_rd(4, v);      chk("R5 first word kept", v, 32'h11);
        chk("R5 single delivery", fn_cnt[4], 1);
        bus_rd(I_STAT, v); chk("R5 status error bit", v, 3);
    endtask

    task automatic t_multi();
        int w; logic [31:0] v;
        bus_wr(5, 32'h55, w);
        bus_wr(6, 32'h66, w);
        chk("R12 second accepted", w, 0);
        bus_rd(I_PEND, v); chk("R12 both pending", v, 32'h60);
        wait_clear(32'h60);
        chk("R12 reg5 delivered", fn_last[5], 32'h55);
        chk("R12 reg6 delivered", fn_last[6], 32'h66);
    endtask

    task automatic t_np_after_posted();
        int w; logic [31:0] v;
        bus_wr(7, 32'h77, w);
        bus_wr(I_IFC, 32'h0, w);
        bus_wr(7, 32'h78, w);
        chk("R2 stall behind posted", {31'b0, w > 0}, 1);
        chk("R2 both delivered", fn_cnt[7], 2);
        chk("R2 last word", fn_last[7], 32'h78);
        bus_rd(7, v); chk("R2 readback after stall", v, 32'h78);
    endtask

    task automatic t_srst();
        int w; logic [31:0] v;
        bus_wr(I_IFC, 32'h4, w);
        bus_wr(0, 32'hBEEF, w);
        bus_wr(I_IFC, 32'h6, w);
        bus_rd(I_STAT, v); chk("R9 busy reads 0", v, 0);
        for (int k = 0; k < 200; k++) begin
            bus_rd(I_STAT, v);
            if (v[0]) break;
        end
        chk("R9 done", v, 1);
        chk("R9 one fn pulse", srst_cnt, 1);
        bus_rd(I_IFC, v); chk("R9 posted cleared", v, 0);
        chk("R9 error cleared", {31'b0, posted_err}, 0);
        bus_rd(0, v);     chk("R9 sync reg cleared", v, 0);
        chk("R9 idle cleared", {30'b0, idle_mode}, 0);
        chk("R9 wake cleared", wake_en, 0);
        bus_wr(3, 32'h33, w);
        chk("R9 stalls again", {31'b0, w > 0}, 1);
        chk("R9 word after reset", fn_last[3], 32'h33);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk_fn);
        rst_fn_n = 1'b1;
        @(negedge clk_bus);
        rst_bus_n = 1'b1;
        repeat (10) @(negedge clk_bus);
        t_reset();
        t_nonposted();
        t_direct();
        t_ignored();
        t_cfg();
        t_posted();
        t_drop();
        t_multi();
        t_np_after_posted();
        t_srst();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule